// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave side of a serial memory device reached over a four-wire SPI link in mode 0. The host lowers chip select and shifts in an 8-bit instruction, most significant bit first. The block can set or clear a write-enable latch, read its status byte, write that status byte, stream bytes out of its array or load bytes into one page of the array. All SPI pins pass through synchronisers into the system clock domain, so SCK must run well below the system clock.

A write does not reach the array while its frame is still being shifted in. The data bytes gather in a page-sized staging buffer. They are copied into the array only when chip select rises exactly at the end of a whole data byte and the write-enable latch is set. The copy starts an internal write cycle that lasts a fixed, parameterised number of system clocks. During that cycle the write-in-progress flag reads 1 and only the status-read instruction is served. The array is a register array with `MEM_BYTES` bytes, divided into pages of `PAGE_BYTES` bytes.

Top module: `spi_mem_slave`

## Requirements
- R1: A WRITE (0x02) or a WRSR (0x01) frame changes the array or the status byte only if the write-enable latch (status bit 1) was already set before the frame began.
- R2: WREN (0x06) sets the latch and WRDI (0x04) clears it, but only when chip select rises right after the 8 opcode bits. If any further clock follows in the same frame, the latch keeps its value.
- R3: A WRITE frame is made of the opcode, a 16-bit address (most significant bit first) and one or more data bytes. Only the low log2(MEM_BYTES) address bits are used.
- R4: Each data byte of a WRITE goes to the next address within the page of the start address. After the last byte of the page, the next byte goes to the first byte of the same page and overwrites what the frame loaded there earlier.
- R5: The internal write cycle starts only if chip select rises right after the last bit of a complete data byte. A rise at any other point leaves the array unchanged and keeps the latch set.
- R6: WRSR followed by exactly one data byte stores data bits 7:2 as status bits 7:2 and starts an internal write cycle. Data bits 1:0 are ignored. A frame with any other length changes nothing.
- R7: For WCYC system clocks after a write or status commit, status bit 0 (WIP) reads 1, and RDSR (0x05) returns the current status byte again after every 8 clocks.
- R8: After reset, SO is not driven and the status byte reads 0x00. No instruction is accepted until chip select has fallen after reset.
- R9: READ (0x03) followed by a 16-bit address returns bytes MSB first, with SO changing on falling SCK. The address advances across the whole array and wraps from the last byte to byte 0.
- R10: When the internal write cycle ends, WIP and the write-enable latch clear in the same clock.
- R11: While WIP is 1, every opcode other than RDSR is ignored for the rest of its frame: SO stays undriven and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for the tri-state SO driver |

## Verification
The end of the internal write cycle can fall in the same system clock as an RDSR byte-boundary reload of the status byte. If WIP cleared without WEL, a poll would catch the mismatch.

The bench provokes this by polling RDSR back to back right after each commit, with write lengths that vary at random. It judges every polled byte against the rule that status bits 1:0 read either both set or both clear, never WIP clear with WEL still set.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 32,
  parameter int WCYC       = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WCYC + 1);
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_WREN = 8'h06;

  logic cs_m, cs_s, cs_d, sck_m, sck_s, sck_d, si_m, si_s;
  logic active, ign, have, wel, wip, oe, so_q;
  logic [2:0] bc;
  logic [1:0] nb;
  logic [6:0] sh;
  logic [7:0] op, ahi, osr;
  logic [5:0] usr, wrsr_d;
  logic [AW-1:0] ptr;
  logic [CW-1:0] wcnt;
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [7:0] mem [MEM_BYTES];

  wire cs_fall  = cs_d & ~cs_s;
  wire cs_rise  = cs_s & ~cs_d;
  wire sck_rise = sck_s & ~sck_d & active & ~cs_s;
  wire sck_fall = ~sck_s & sck_d & active & ~cs_s;
  wire [7:0] nbyte = {sh, si_s};
  wire [7:0] status = {usr, wel, wip};
  wire [AW-1:0] a_st = AW'({ahi, nbyte});
  wire ok_end = active & ~ign & ~wip & (bc == 3'd0);

  assign so    = so_q;
  assign so_oe = oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_m <= 1'b0; cs_s <= 1'b0; cs_d <= 1'b0;
      sck_m <= 1'b0; sck_s <= 1'b0; sck_d <= 1'b0;
      si_m <= 1'b0; si_s <= 1'b0;
      active <= 1'b0; ign <= 1'b0; have <= 1'b0;
      wel <= 1'b0; wip <= 1'b0; oe <= 1'b0; so_q <= 1'b0;
      bc <= '0; nb <= '0; sh <= '0; op <= '0; ahi <= '0; osr <= '0;
      usr <= '0; wrsr_d <= '0; ptr <= '0; wcnt <= '0; mask <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else begin
      cs_m <= cs_n;  cs_s <= cs_m;  cs_d <= cs_s;
      sck_m <= sck;  sck_s <= sck_m; sck_d <= sck_s;
      si_m <= si;    si_s <= si_m;

      if (wip) begin
        if (wcnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else wcnt <= wcnt - 1'b1;
      end

      if (cs_fall) begin
        active <= 1'b1; bc <= '0; nb <= '0; mask <= '0;
        ign <= 1'b0; have <= 1'b0; oe <= 1'b0;
      end else if (cs_rise) begin
        active <= 1'b0;
        oe <= 1'b0;
        if (ok_end) begin
          case (op)
            OP_WREN: if (nb == 2'd1) wel <= 1'b1;
            OP_WRDI: if (nb == 2'd1) wel <= 1'b0;
            OP_WRSR: if (nb == 2'd2 && wel) begin
              usr <= wrsr_d;
              wip <= 1'b1;
              wcnt <= CW'(WCYC - 1);
            end
            OP_WRITE: if (nb == 2'd3 && have && wel) begin
              for (int i = 0; i < PAGE_BYTES; i++)
                if (mask[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
              wip <= 1'b1;
              wcnt <= CW'(WCYC - 1);
            end
            default: ;
          endcase
        end
      end else if (sck_rise) begin
        sh <= nbyte[6:0];
        bc <= bc + 1'b1;
        if (bc == 3'd7) begin
          if (nb != 2'd3) nb <= nb + 1'b1;
          if (nb == 2'd0) begin
            op  <= nbyte;
            ign <= wip && (nbyte != OP_RDSR);
            if (nbyte == OP_RDSR) begin
              osr <= status;
              oe  <= 1'b1;
            end
          end else if (!ign) begin
            case (op)
              OP_RDSR: osr <= status;
              OP_WRSR: if (nb == 2'd1) wrsr_d <= nbyte[7:2];
              OP_READ: begin
                if (nb == 2'd1) ahi <= nbyte;
                else if (nb == 2'd2) begin
                  osr <= mem[a_st];
                  ptr <= a_st + 1'b1;
                  oe  <= 1'b1;
                end else begin
                  osr <= mem[ptr];
                  ptr <= ptr + 1'b1;
                end
              end
              OP_WRITE: begin
                if (nb == 2'd1) ahi <= nbyte;
                else if (nb == 2'd2) ptr <= a_st;
                else begin
                  pbuf[ptr[PW-1:0]] <= nbyte;
                  mask[ptr[PW-1:0]] <= 1'b1;
                  ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
                  have <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      end else if (sck_fall && oe) begin
        so_q <= osr[7];
        osr  <= {osr[6:0], 1'b0};
      end
    end
  end

  assert_wel_before_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wel));
  assert_cycle_starts_on_cs_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(cs_rise));
  assert_wel_clears_with_wip_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel);
  assert_so_released_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_s) |=> !so_oe);
  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (rst)
    (wip && sck_rise && bc == 3'd7 && nb == 2'd0 && nbyte != OP_RDSR) |=> !so_oe);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !active |=> !so_oe);
endmodule

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b0, sck = 1'b0, si = 1'b0;
  wire so, so_oe;
  always #2.5 clk = ~clk;

  spi_mem_slave uut (.clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe));

  localparam int H = 5;
  int nchk = 0, nbad = 0;
  logic [7:0] mdl [256];
  logic [7:0] mstat = 8'h00;

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx, output logic anyoe);
    rx = 8'h00; anyoe = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk) si = tx[7-k];
      repeat (H) @(negedge clk);
      rx = {rx[6:0], so};
      anyoe |= so_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx; logic oe;
    sel; xbits(op, 8, rx, oe); desel;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic oe;
    sel; xbits(8'h05, 8, s, oe); xbits(8'h00, 8, s, oe); desel;
  endtask

  task automatic wframe(input logic [7:0] op, input logic [15:0] a, input logic [7:0] d[$], input int tail);
    logic [7:0] rx; logic oe;
    sel;
    xbits(op, 8, rx, oe);
    if (op == 8'h02) begin
      xbits(a[15:8], 8, rx, oe);
      xbits(a[7:0], 8, rx, oe);
    end
    foreach (d[i]) xbits(d[i], 8, rx, oe);
    if (tail > 0) xbits(8'h00, tail, rx, oe);
    desel;
  endtask

  task automatic rd(input logic [15:0] a, input int n, output logic [7:0] q[$], output logic alloe, output logic anyoe);
    logic [7:0] rx; logic oe;
    q = {}; alloe = 1'b1; anyoe = 1'b0;
    sel;
    xbits(8'h03, 8, rx, oe);
    xbits(a[15:8], 8, rx, oe);
    xbits(a[7:0], 8, rx, oe);
    for (int i = 0; i < n; i++) begin
      xbits(8'h00, 8, rx, oe);
      q.push_back(rx);
      alloe &= oe;
      anyoe |= oe;
    end
    desel;
  endtask

  function automatic void mwrite(input int a, input logic [7:0] d[$]);
    int base = a & 8'hE0;
    int off  = a & 31;
    foreach (d[i]) mdl[base + ((off + i) & 31)] = d[i];
  endfunction

  task automatic poll(input string r);
    logic [7:0] s;
    int n = 0;
    do begin
      rdsr(s);
      n++;
      if (s[1:0] == 2'b01 || (s[1:0] == 2'b10 && n == 1)) chk(r, s[1:0], 2'b11);
    end while (s[0] && n < 50);
    chk("R10", s[1:0], 2'b00);
    mstat[1] = 1'b0;
  endtask

  task automatic cmp_page(input int base, input string r);
    logic [7:0] q[$]; logic ao, an;
    rd(16'(base), 32, q, ao, an);
    chk("R9 oe", ao, 1);
    foreach (q[i]) chk(r, q[i], mdl[base + i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary;
  end

  initial begin
    logic [7:0] s, rx;
    logic oe, ao, an;
    logic [7:0] d[$], q[$];
    void'($urandom(32'd2024));
    foreach (mdl[i]) mdl[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R8: CS low since reset, no falling edge: RDSR must not be served
    xbits(8'h05, 8, rx, oe);
    xbits(8'h00, 8, rx, oe);
    chk("R8 no frame without cs fall", oe, 0);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
    chk("R8 so_oe idle", so_oe, 0);
    rdsr(s);
    chk("R8 status after reset", s, 8'h00);

    // R1: write without WREN
    d = '{8'h5A};
    wframe(8'h02, 16'h0040, d, 0);
    rdsr(s);
    chk("R1 no cycle without wel", s, 8'h00);
    rd(16'h0040, 1, q, ao, an);
    chk("R1 array unchanged", q[0], 8'h00);

    // R2: WREN followed by more clocks
    sel; xbits(8'h06, 8, rx, oe); xbits(8'h00, 8, rx, oe); desel;
    rdsr(s);
    chk("R2 wren extra clocks", s, 8'h00);
    cmd(8'h06);
    rdsr(s);
    chk("R2 wren sets wel", s, 8'h02);
    mstat[1] = 1'b1;

    // R5: abort mid-byte
    d = '{8'hAA};
    wframe(8'h02, 16'h0010, d, 4);
    rdsr(s);
    chk("R5 abort keeps wel, no wip", s, 8'h02);
    rd(16'h0010, 1, q, ao, an);
    chk("R5 array unchanged", q[0], 8'h00);

    // R3/R4: page wrap, then R11 during cycle
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    wframe(8'h02, 16'h001E, d, 0);
    mwrite(16'h1E, d);
    rd(16'h0000, 2, q, ao, an);
    chk("R11 read ignored while busy", an, 0);
    poll("R7");
    cmp_page(0, "R4 wrap in page");

    // R6: status write
    cmd(8'h06);
    d = '{8'hFF};
    wframe(8'h01, 16'h0, d, 0);
    rdsr(s);
    chk("R7 wip set after wrsr", s[0], 1);
    poll("R7");
    rdsr(s);
    chk("R6 bits 1:0 ignored", s, 8'hFC);
    cmd(8'h06);
    d = '{8'h00, 8'h00};
    wframe(8'h01, 16'h0, d, 0);
    rdsr(s);
    chk("R6 two-byte wrsr rejected", s, 8'hFE);
    cmd(8'h04);
    rdsr(s);
    chk("R2 wrdi clears wel", s, 8'hFC);

    // R9: stream across array end
    cmd(8'h06);
    d = '{8'hC1, 8'hC2};
    wframe(8'h02, 16'h00FF, d, 0);
    mwrite(16'hFF, d);
    poll("R7");
    d = '{8'hD0};
    cmd(8'h06);
    wframe(8'h02, 16'h0000, d, 0);
    mwrite(0, d);
    poll("R7");
    rd(16'h00FE, 4, q, ao, an);
    chk("R9 oe", ao, 1);
    for (int i = 0; i < 4; i++) chk("R9 wrap array end", q[i], mdl[(16'hFE + i) & 255]);

    // R3/R4/R5 random page writes
    for (int it = 0; it < 10; it++) begin
      int a = $urandom_range(0, 255);
      int n = $urandom_range(1, 36);
      d = {};
      for (int i = 0; i < n; i++) d.push_back(8'($urandom));
      cmd(8'h06);
      wframe(8'h02, 16'(a), d, 0);
      mwrite(a, d);
      poll("R7");
      cmp_page(a & 8'hE0, "R3 random write");
    end

    summary;
  end
endmodule